// File: doc/BRIEF.md
# Sixteen-Channel Multihit Pattern Register

This block captures hits on sixteen front-panel channels. Each channel has two set flops in cascade. The first flop records that at least one hit has arrived since the last clear. The second flop records that a further hit arrived while the first was already set. Software reaches the block through a small synchronous register bus. Over that bus it reads the two hit patterns (plainly, or with a clear after the read), qualifies hits per channel and through a common gate, injects hits by writing, clears every channel, and shapes the channel outputs.

Each channel output follows one of two flops. In I/O-register mode it follows the first flop; in multihit mode it follows the second. A per-channel mask can suppress that flop-driven output, and a per-channel force bit can drive the output active regardless. All inputs arrive already synchronised to `clk`. The block takes a hit to be a rising edge of a channel input, sampled once per clock.

Top module: `hit_pattern_reg`

## Requirements
- R1: A qualified hit sets a channel's first flop. A qualified hit that arrives while the first flop is already set also sets the channel's second flop, so the pair shows no hit, one hit, or two or more hits.
- R2: A read at address 3 returns the first flops, bit n for channel n. A read at address 4 returns the second flops. Read data appears on `bus_rdata` one cycle after the `bus_rd` cycle, and is 0 in every cycle that follows no read.
- R3: A read at address 8 returns the first-flop pattern and clears exactly the first flops that were set when it was read. A read at address 9 does the same for the second flops. A hit arriving in the read cycle is kept.
- R4: A write to address 7 clears both flops of every channel and the input-set register at address 0. A cycle with `clear_in` high clears both flops of every channel. Either clear wins over a hit in the same cycle.
- R5: A write to address 0 stores the value, which reads back at address 0. Each 1 in the written data counts as one hit on that channel, whatever the input level and whatever the input-mask and gate settings.
- R6: A 1 in the input-mask register (address 1) blocks the front-panel hits of that channel.
- R7: Control register (address 10) bit 0 selects how the gate is used. When the bit is 1 the gate is ignored; this is its reset value. When the bit is 0, front-panel hits count only while `gate_in` is high.
- R8: A read at address 2 returns the live levels of `hit_in`, whatever the input mask.
- R9: Control bit 1 selects the output source. When it is 0, `ch_out[n]` follows channel n's first flop. When it is 1, `ch_out[n]` follows the second flop.
- R10: A 1 in the output-mask register (address 5) suppresses the flop-driven output of that channel. A 1 in the output-set register (address 6) drives the output high regardless of mask or flops.
- R11: After reset every register and flop is 0, except that the control register reads 0x0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_in | input | 16 | Synchronised channel inputs |
| gate_in | input | 1 | Common hit gate |
| clear_in | input | 1 | Front-panel clear of all flops |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| ch_out | output | 16 | Channel outputs |

## Verification
The assertions hold on every cycle for the local rules of each channel. A second flop never rises unless its first flop was set. Neither flop rises through a mask or a closed gate, except by a software set. Both flops are zero after a global clear. A single-hit read returns the flop state from the cycle of the read. Only the bench's scenarios can show the counting across several hits, the read-clear behaviour with a hit arriving in the same cycle, the mode and output mask/force combinations, and the reset values read over the bus.

// File: rtl/hpr_pkg.sv
// Package: register addresses and control-bit positions shared by the
// multihit pattern register and its bench.
package hpr_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_INSET  = 4'd0;
    localparam logic [ADDR_W-1:0] A_INMASK = 4'd1;
    localparam logic [ADDR_W-1:0] A_INLVL  = 4'd2;
    localparam logic [ADDR_W-1:0] A_SH     = 4'd3;
    localparam logic [ADDR_W-1:0] A_MH     = 4'd4;
    localparam logic [ADDR_W-1:0] A_OMASK  = 4'd5;
    localparam logic [ADDR_W-1:0] A_OSET   = 4'd6;
    localparam logic [ADDR_W-1:0] A_CLR    = 4'd7;
    localparam logic [ADDR_W-1:0] A_SH_RC  = 4'd8;
    localparam logic [ADDR_W-1:0] A_MH_RC  = 4'd9;
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd10;

    localparam int CB_GATE_IGN = 0;
    localparam int CB_MODE     = 1;
endpackage

// File: rtl/hpr_channel.sv
// Module: one hit-capture channel.
// Does: detects rising edges of its input and records them in two cascaded
//       set flops (first hit, repeat hit). Supports a software hit pulse, a
//       global clear and separate read-clear requests for each flop.
// Assumes: lvl_i is already synchronised; the clear requests are one-cycle
//          strobes; a global clear has priority over a hit in the same cycle.
module hpr_channel (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic mask_i,
    input  logic gate_ok_i,
    input  logic set_pls_i,
    input  logic gclr_i,
    input  logic rc1_i,
    input  logic rc2_i,
    output logic s1_q,
    output logic s2_q
);
    logic lvl_q;
    logic ev;

    // Purpose: remember the previous input level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_i;
    end

    // Purpose: form a hit from a qualified front-panel edge or a software set.
    always_comb begin
        ev = (lvl_i & ~lvl_q & ~mask_i & gate_ok_i) | set_pls_i;
    end

    // Purpose: update the two cascaded capture flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= (s1_q & ~rc1_i & ~gclr_i) | (ev & ~gclr_i);
            s2_q <= (s2_q & ~rc2_i & ~gclr_i) | (ev & s1_q & ~gclr_i);
        end
    end

    // R1: the repeat flop only rises when the first flop was already set
    a_r1_second_needs_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s2_q) |-> $past(s1_q));
    // R4: a global clear leaves both flops empty
    a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        gclr_i |=> (!s1_q && !s2_q));
    // R6: a masked channel only captures through a software set
    a_r6_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s1_q) |-> $past(!mask_i || set_pls_i));
    // R7: a closed gate only lets software sets through
    a_r7_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s1_q) |-> $past(gate_ok_i || set_pls_i));
endmodule

// File: rtl/hpr_regs.sv
// Module: register file and bus decode of the multihit pattern register.
// Does: holds the input-set, input-mask, output-mask, output-set and control
//       registers. Decodes writes, produces the software-set pulse, the clear
//       strobe and the read-clear vectors, and registers the read data.
// Assumes: single-cycle read and write strobes; read data one cycle later.
module hpr_regs #(
    parameter int N_CH = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [hpr_pkg::ADDR_W-1:0] bus_addr,
    input  logic [N_CH-1:0]           bus_wdata,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [N_CH-1:0]           lvl_i,
    input  logic [N_CH-1:0]           s1_i,
    input  logic [N_CH-1:0]           s2_i,
    output logic [N_CH-1:0]           bus_rdata,
    output logic [N_CH-1:0]           inmask_q,
    output logic [N_CH-1:0]           omask_q,
    output logic [N_CH-1:0]           oset_q,
    output logic                      gate_ign_q,
    output logic                      mode_q,
    output logic [N_CH-1:0]           set_pls,
    output logic                      clr_wr,
    output logic [N_CH-1:0]           rc1,
    output logic [N_CH-1:0]           rc2
);
    import hpr_pkg::*;

    logic [N_CH-1:0] inset_q;
    logic [N_CH-1:0] rsel;
    logic [N_CH-1:0] ctrl_rd;

    // Purpose: decode write-side strobes and read-clear requests.
    always_comb begin
        set_pls = (bus_wr && bus_addr == A_INSET) ? bus_wdata : '0;
        clr_wr  = bus_wr && bus_addr == A_CLR;
        rc1     = (bus_rd && bus_addr == A_SH_RC) ? s1_i : '0;
        rc2     = (bus_rd && bus_addr == A_MH_RC) ? s2_i : '0;
        ctrl_rd = '0;
        ctrl_rd[CB_GATE_IGN] = gate_ign_q;
        ctrl_rd[CB_MODE]     = mode_q;
    end

    // Purpose: hold the software-written registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inset_q    <= '0;
            inmask_q   <= '0;
            omask_q    <= '0;
            oset_q     <= '0;
            gate_ign_q <= 1'b1;
            mode_q     <= 1'b0;
        end else begin
            if (bus_wr) begin
                case (bus_addr)
                    A_INSET:  inset_q  <= bus_wdata;
                    A_INMASK: inmask_q <= bus_wdata;
                    A_OMASK:  omask_q  <= bus_wdata;
                    A_OSET:   oset_q   <= bus_wdata;
                    A_CLR:    inset_q  <= '0;
                    A_CTRL: begin
                        gate_ign_q <= bus_wdata[CB_GATE_IGN];
                        mode_q     <= bus_wdata[CB_MODE];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Purpose: select the register addressed by a read.
    always_comb begin
        case (bus_addr)
            A_INSET:  rsel = inset_q;
            A_INMASK: rsel = inmask_q;
            A_INLVL:  rsel = lvl_i;
            A_SH:     rsel = s1_i;
            A_MH:     rsel = s2_i;
            A_OMASK:  rsel = omask_q;
            A_OSET:   rsel = oset_q;
            A_SH_RC:  rsel = s1_i;
            A_MH_RC:  rsel = s2_i;
            A_CTRL:   rsel = ctrl_rd;
            default:  rsel = '0;
        endcase
    end

    // Purpose: register the read data; zero when no read took place.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= bus_rd ? rsel : '0;
    end

    // R2: a single-hit read returns the flops as they were in the read cycle
    a_r2_read_single: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_SH) |=> bus_rdata == $past(s1_i));
endmodule

// File: rtl/hit_pattern_reg.sv
// Module: sixteen-channel multihit pattern register (top).
// Does: instantiates one capture channel per input and the register file,
//       combines the clears and the gate, and drives the channel outputs by
//       mode, output mask and output force.
// Assumes: all inputs synchronous to clk; N_CH matches the bus data width.
module hit_pattern_reg #(
    parameter int N_CH = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_CH-1:0]           hit_in,
    input  logic                      gate_in,
    input  logic                      clear_in,
    input  logic [hpr_pkg::ADDR_W-1:0] bus_addr,
    input  logic [N_CH-1:0]           bus_wdata,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    output logic [N_CH-1:0]           bus_rdata,
    output logic [N_CH-1:0]           ch_out
);
    logic [N_CH-1:0] s1, s2, inmask, omask, oset, set_pls, rc1, rc2;
    logic            gate_ign, mode, clr_wr, gclr, gate_ok;

    hpr_regs #(.N_CH(N_CH)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .lvl_i(hit_in), .s1_i(s1), .s2_i(s2),
        .bus_rdata(bus_rdata), .inmask_q(inmask), .omask_q(omask),
        .oset_q(oset), .gate_ign_q(gate_ign), .mode_q(mode),
        .set_pls(set_pls), .clr_wr(clr_wr), .rc1(rc1), .rc2(rc2)
    );

    // Purpose: merge the two clear sources and qualify the common gate.
    always_comb begin
        gclr    = clr_wr | clear_in;
        gate_ok = gate_ign | gate_in;
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        hpr_channel u_ch (
            .clk(clk), .rst_n(rst_n), .lvl_i(hit_in[i]), .mask_i(inmask[i]),
            .gate_ok_i(gate_ok), .set_pls_i(set_pls[i]), .gclr_i(gclr),
            .rc1_i(rc1[i]), .rc2_i(rc2[i]), .s1_q(s1[i]), .s2_q(s2[i])
        );

        // Purpose: pick the flop by mode, then apply mask and force.
        always_comb begin
            ch_out[i] = ((mode ? s2[i] : s1[i]) & ~omask[i]) | oset[i];
        end
    end
endmodule

// File: tb/sim_hit_pattern_reg.sv
`timescale 1ns/1ps
module sim_hit_pattern_reg;
    localparam int N = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  hit_in = '0;
    logic          gate_in = 1'b0;
    logic          clear_in = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [N-1:0]  bus_rdata;
    logic [N-1:0]  ch_out;

    int total = 0;
    int bad = 0;
    logic rd_d = 1'b0;
    logic [N-1:0] exp_q[$];
    string        tag_q[$];

    hit_pattern_reg #(.N_CH(N)) u0 (
        .clk(clk), .rst_n(rst_n), .hit_in(hit_in), .gate_in(gate_in),
        .clear_in(clear_in), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .ch_out(ch_out)
    );

    always #2.5 clk = ~clk;

    task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop the expected read value in the cycle after each read.
    always @(posedge clk) rd_d <= bus_rd;
    always @(negedge clk) begin
        if (rd_d) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL scoreboard empty actual=%h expected=none", bus_rdata);
            end else begin
                check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end else if (rst_n && bus_rdata !== '0) begin
            total++; bad++;
            $display("FAIL R2 idle rdata actual=%h expected=0000", bus_rdata);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [N-1:0] exp, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input logic [N-1:0] m);
        hit_in = m;
        @(negedge clk);
        hit_in = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset values
        rd(4'd10, 16'h0001, "R11 ctrl reset");
        rd(4'd0, 16'h0000, "R11 inset reset");
        rd(4'd1, 16'h0000, "R11 inmask reset");
        rd(4'd5, 16'h0000, "R11 omask reset");
        rd(4'd6, 16'h0000, "R11 oset reset");
        rd(4'd3, 16'h0000, "R11 single reset");
        check(ch_out, 16'h0000, "R11 outputs reset");

        // R1/R2: one, two and three hits
        pulse(16'h0007);
        pulse(16'h0006);
        pulse(16'h0004);
        rd(4'd3, 16'h0007, "R1 R2 single pattern");
        rd(4'd4, 16'h0006, "R1 R2 multi pattern");
        check(ch_out, 16'h0007, "R9 io mode output");

        // R9: multihit mode
        wr(4'd10, 16'h0003);
        check(ch_out, 16'h0006, "R9 multihit mode output");
        // R10: mask and force
        wr(4'd5, 16'h0002);
        check(ch_out, 16'h0004, "R10 output mask");
        wr(4'd6, 16'h8000);
        check(ch_out, 16'h8004, "R10 output force");
        wr(4'd6, 16'h0000);
        wr(4'd5, 16'h0000);
        wr(4'd10, 16'h0001);

        // R3: read-clear of the repeat flops
        rd(4'd9, 16'h0006, "R3 multi read-clear value");
        rd(4'd4, 16'h0000, "R3 multi cleared");
        rd(4'd3, 16'h0007, "R3 single untouched");
        // R3: single read-clear with a new hit in the same cycle
        hit_in = 16'h0008;
        rd(4'd8, 16'h0007, "R3 single read-clear value");
        hit_in = '0;
        @(negedge clk);
        rd(4'd3, 16'h0008, "R3 same-cycle hit kept");

        // R5: software set, independent of input level
        wr(4'd0, 16'h0030);
        rd(4'd0, 16'h0030, "R5 inset readback");
        wr(4'd0, 16'h0010);
        rd(4'd3, 16'h0038, "R5 single after set");
        rd(4'd4, 16'h0010, "R5 multi after second set");

        // R4: clear-output write
        wr(4'd7, 16'h0000);
        rd(4'd3, 16'h0000, "R4 single cleared");
        rd(4'd4, 16'h0000, "R4 multi cleared");
        rd(4'd0, 16'h0000, "R4 inset cleared");
        // R4: front clear beats a same-cycle hit
        pulse(16'h0001);
        clear_in = 1'b1; hit_in = 16'h0002;
        @(negedge clk);
        clear_in = 1'b0; hit_in = '0;
        @(negedge clk);
        rd(4'd3, 16'h0000, "R4 front clear wins");

        // R6: input mask
        wr(4'd1, 16'h0001);
        pulse(16'h0003);
        rd(4'd3, 16'h0002, "R6 masked channel blocked");
        wr(4'd1, 16'h0000);
        wr(4'd7, 16'h0000);

        // R7: gate in use
        wr(4'd10, 16'h0000);
        gate_in = 1'b0;
        pulse(16'h0001);
        gate_in = 1'b1;
        pulse(16'h0002);
        gate_in = 1'b0;
        rd(4'd3, 16'h0002, "R7 gate qualifies hits");
        wr(4'd10, 16'h0001);
        wr(4'd7, 16'h0000);

        // R8: live levels ignore the mask
        wr(4'd1, 16'h00F0);
        hit_in = 16'h00F0;
        @(negedge clk);
        rd(4'd2, 16'h00F0, "R8 live input levels");
        hit_in = '0;
        @(negedge clk);
        wr(4'd1, 16'h0000);
        rd(4'd3, 16'h0000, "R6 masked levels left no hit");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule